// File: doc/BRIEF.md
# Address Window Decoder with Access Attributes

This block sits on the outgoing address path of a DMA engine and turns each system address into a target selection. Up to eight programmable windows each hold a base address, a size mask, a target ID, an attribute byte, an enable bit and a two-bit permission field. A request is matched against every enabled window in parallel. The lowest-indexed matching window supplies the target ID and attribute byte that steer the access, for example to one DRAM chip select or to on-chip SRAM.

Software sets up the windows through a simple register port. Writes take effect at the clock edge, and reads return the stored value combinationally. Each request is answered one cycle later with the window index, target ID, attribute byte and that window's read and write permissions. An address that no enabled window claims raises a miss error. An access that the matched window does not permit raises a protection error.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero and every window is disabled, so any request misses; all response outputs are zero while reset is held.
- R2: Register map on `reg_addr`: 0 is the control word, 8+i is the base register of window i, and 16+i is the size register of window i. In the control word, bit i enables window i and bits [17+2i:16+2i] hold its permission field. The base register holds the base in bits [31:16], the attribute byte in [15:8] and the target ID in [3:0]. The size register holds the size field in [31:16]. All other bits read as zero, and a write changes only the addressed register.
- R3: Window i matches when (addr[31:16] AND NOT size_i) equals base_i[31:16]. The size field is the window length in 64 KB units minus one, so a window covers (size_i+1)×64 KB from its base.
- R4: When several enabled windows match, the lowest index is reported.
- R5: `rsp_valid` is high in the cycle after `req_valid`. On a match, `rsp_hit`=1 and `rsp_win`, `rsp_target` and `rsp_attr` carry the matched window's index, target ID and attribute byte.
- R6: When no enabled window matches, `rsp_miss_err` is high for that response and `rsp_hit`, `rsp_win`, `rsp_target`, `rsp_attr`, `rsp_rd_ok` and `rsp_wr_ok` are all zero.
- R7: In the permission field, bit 0 grants reads and bit 1 grants writes; the value 3 gives full access. `rsp_rd_ok` and `rsp_wr_ok` report those two bits of the matched window.
- R8: A matched write without the write bit, or a matched read without the read bit, sets `rsp_prot_err`. The window is still reported, and `rsp_miss_err` stays low.
- R9: A window whose enable bit is clear never matches, whatever its base and size.
- R10: In a cycle after one with `req_valid` low, `rsp_valid`, `rsp_miss_err` and `rsp_prot_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | System address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the matched window |
| rsp_target | output | 4 | Target ID of the matched window |
| rsp_attr | output | 8 | Attribute byte of the matched window |
| rsp_rd_ok | output | 1 | Matched window permits reads |
| rsp_wr_ok | output | 1 | Matched window permits writes |
| rsp_miss_err | output | 1 | No enabled window matched |
| rsp_prot_err | output | 1 | Access not permitted by the matched window |

## Verification
The assertions assume that `req_valid` and `reg_wr` are driven to known values from reset onward. They also assume that the register and request inputs are stable across each clock edge, so that every response reflects exactly one sampled request. The stimulus changes every input only on the falling clock edge and releases `req_valid` after each request. It programs bases aligned to their sizes, as set out in R3, and samples results half a cycle after the edge that registers them.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int TW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [4:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    req_valid,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_write,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [$clog2(NWIN)-1:0] rsp_win,
  output logic [TW-1:0]           rsp_target,
  output logic [7:0]              rsp_attr,
  output logic                    rsp_rd_ok,
  output logic                    rsp_wr_ok,
  output logic                    rsp_miss_err,
  output logic                    rsp_prot_err
);
  localparam int IW   = $clog2(NWIN);
  localparam int HW   = AW - 16;
  localparam int BOFS = 8;
  localparam int SOFS = 16;

  logic [NWIN-1:0] en_q;
  logic [1:0]      acc_q  [NWIN];
  logic [HW-1:0]   base_q [NWIN];
  logic [HW-1:0]   size_q [NWIN];
  logic [7:0]      attr_q [NWIN];
  logic [TW-1:0]   tgt_q  [NWIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NWIN; i++) begin
        acc_q[i]  <= '0;
        base_q[i] <= '0;
        size_q[i] <= '0;
        attr_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == 5'd0) begin
        for (int i = 0; i < NWIN; i++) begin
          en_q[i]  <= reg_wdata[i];
          acc_q[i] <= reg_wdata[16+2*i +: 2];
        end
      end
      for (int i = 0; i < NWIN; i++) begin
        if (reg_addr == 5'(BOFS + i)) begin
          base_q[i] <= reg_wdata[31 -: HW];
          attr_q[i] <= reg_wdata[15:8];
          tgt_q[i]  <= reg_wdata[TW-1:0];
        end
        if (reg_addr == 5'(SOFS + i))
          size_q[i] <= reg_wdata[31 -: HW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 5'd0)
      for (int i = 0; i < NWIN; i++) begin
        reg_rdata[i]            = en_q[i];
        reg_rdata[16+2*i +: 2]  = acc_q[i];
      end
    for (int i = 0; i < NWIN; i++) begin
      if (reg_addr == 5'(BOFS + i)) begin
        reg_rdata[31 -: HW]   = base_q[i];
        reg_rdata[15:8]       = attr_q[i];
        reg_rdata[TW-1:0]     = tgt_q[i];
      end
      if (reg_addr == 5'(SOFS + i))
        reg_rdata[31 -: HW]   = size_q[i];
    end
  end

  logic [NWIN-1:0] hit;
  for (genvar g = 0; g < NWIN; g++) begin : g_match
    assign hit[g] = en_q[g] && ((req_addr[AW-1:16] & ~size_q[g]) == base_q[g]);
  end

  logic          any_hit;
  logic [IW-1:0] win;
  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) begin
        any_hit = 1'b1;
        win     = IW'(i);
      end
  end

  wire [1:0] sel_acc = any_hit ? acc_q[win] : 2'b00;
  wire       denied  = any_hit && (req_write ? !sel_acc[1] : !sel_acc[0]);
  logic unused_low;
  assign unused_low = ^req_addr[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_win      <= '0;
      rsp_target   <= '0;
      rsp_attr     <= '0;
      rsp_rd_ok    <= 1'b0;
      rsp_wr_ok    <= 1'b0;
      rsp_miss_err <= 1'b0;
      rsp_prot_err <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= req_valid && any_hit;
      rsp_win      <= (req_valid && any_hit) ? win : '0;
      rsp_target   <= (req_valid && any_hit) ? tgt_q[win] : '0;
      rsp_attr     <= (req_valid && any_hit) ? attr_q[win] : '0;
      rsp_rd_ok    <= req_valid && sel_acc[0];
      rsp_wr_ok    <= req_valid && sel_acc[1];
      rsp_miss_err <= req_valid && !any_hit;
      rsp_prot_err <= req_valid && denied;
    end
  end

  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_miss_err && !rsp_prot_err));
  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss_err |-> (!rsp_hit && rsp_attr == 8'h00 && rsp_target == '0 && !rsp_rd_ok && !rsp_wr_ok));
  p_prot_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_err |-> (rsp_hit && !rsp_miss_err));
  p_hit_not_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss_err));
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_q));
endmodule

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_rd_ok, rsp_wr_ok, rsp_miss_err, rsp_prot_err;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_window_decoder i_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_target(rsp_target),
    .rsp_attr(rsp_attr), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
    .rsp_miss_err(rsp_miss_err), .rsp_prot_err(rsp_prot_err));

  // packed response: valid,hit,win[3],tgt[4],attr[8],rd,wr,miss,prot
  function automatic logic [20:0] rsp(input logic v, h, input logic [2:0] w,
      input logic [3:0] t, input logic [7:0] a, input logic rd, wr, ms, pe);
    return {v, h, w, t, a, rd, wr, ms, pe};
  endfunction
  wire [20:0] got = {rsp_valid, rsp_hit, rsp_win, rsp_target, rsp_attr,
                     rsp_rd_ok, rsp_wr_ok, rsp_miss_err, rsp_prot_err};
  localparam logic [20:0] MISS = 21'h100002;

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic req(input string tag, input logic [31:0] a, input logic w,
                     input logic [20:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    check(tag, {11'b0, got}, {11'b0, exp});
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 outputs in reset", {11'b0, got}, 32'h0);
    rst_n = 1'b1;
    rreg("R1 ctrl reads zero", 5'd0, 32'h0);
    rreg("R1 base0 reads zero", 5'd8, 32'h0);
    req("R1 R6 miss after reset", 32'h0000_0000, 1'b0, MISS);
  endtask

  task automatic t_regs;
    wreg(5'd0, 32'hFFFF_FFFF);
    rreg("R2 ctrl fields", 5'd0, 32'hFFFF_00FF);
    wreg(5'd10, 32'hFFFF_FFFF);
    rreg("R2 base fields", 5'd10, 32'hFFFF_FF0F);
    wreg(5'd18, 32'hFFFF_FFFF);
    rreg("R2 size fields", 5'd18, 32'hFFFF_0000);
    rreg("R2 other base untouched", 5'd9, 32'h0);
  endtask

  task automatic t_program;
    wreg(5'd8,  32'h0000_0E00); wreg(5'd16, 32'h0FFF_0000);
    wreg(5'd9,  32'h1000_0D00); wreg(5'd17, 32'h0FFF_0000);
    wreg(5'd10, 32'h2000_0B00); wreg(5'd18, 32'h0FFF_0000);
    wreg(5'd11, 32'h3000_0700); wreg(5'd19, 32'h0FFF_0000);
    wreg(5'd12, 32'h4000_1F01); wreg(5'd20, 32'h000F_0000);
    wreg(5'd0,  32'h01FF_001F);
  endtask

  task automatic t_match;
    req("R3 R5 win1 read", 32'h1234_5678, 1'b0, rsp(1,1,3'd1,4'd0,8'h0D,1,1,0,0));
    req("R5 win0 write", 32'h0000_0000, 1'b1, rsp(1,1,3'd0,4'd0,8'h0E,1,1,0,0));
    req("R3 win3 top edge", 32'h3FFF_FFFC, 1'b0, rsp(1,1,3'd3,4'd0,8'h07,1,1,0,0));
    req("R5 win2 write", 32'h2000_0000, 1'b1, rsp(1,1,3'd2,4'd0,8'h0B,1,1,0,0));
    req("R3 R7 sram last byte", 32'h400F_FFFF, 1'b0, rsp(1,1,3'd4,4'd1,8'h1F,1,0,0,0));
    req("R3 R6 past sram end", 32'h4010_0000, 1'b0, MISS);
    req("R6 unmapped", 32'h5000_0000, 1'b1, MISS);
  endtask

  task automatic t_prot;
    req("R8 write to read-only", 32'h4000_1000, 1'b1, rsp(1,1,3'd4,4'd1,8'h1F,1,0,0,1));
    req("R7 read of read-only", 32'h4000_1000, 1'b0, rsp(1,1,3'd4,4'd1,8'h1F,1,0,0,0));
  endtask

  task automatic t_priority;
    wreg(5'd13, 32'h1000_5502); wreg(5'd21, 32'h0FFF_0000);
    wreg(5'd0, 32'h0DFF_003F);
    req("R4 lowest index wins", 32'h1000_0010, 1'b0, rsp(1,1,3'd1,4'd0,8'h0D,1,1,0,0));
    wreg(5'd0, 32'h0DFF_003D);
    req("R9 R4 disabled win1 skipped", 32'h1000_0010, 1'b0, rsp(1,1,3'd5,4'd2,8'h55,1,1,0,0));
  endtask

  task automatic t_disabled;
    wreg(5'd14, 32'h8000_0E03); wreg(5'd22, 32'h0000_0000);
    req("R9 disabled window ignored", 32'h8000_0000, 1'b0, MISS);
    wreg(5'd0, 32'h0DFF_007D);
    req("R8 no-access window read", 32'h8000_FFFF, 1'b0, rsp(1,1,3'd6,4'd3,8'h0E,0,0,0,1));
    req("R3 64KB window edge", 32'h8001_0000, 1'b0, MISS);
  endtask

  task automatic t_idle;
    req("R5 back to window0", 32'h0000_1000, 1'b0, rsp(1,1,3'd0,4'd0,8'h0E,1,1,0,0));
    @(negedge clk);
    check("R10 idle response quiet", {11'b0, got}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_program;
    t_match;
    t_prot;
    t_priority;
    t_disabled;
    t_idle;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule